// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Pipeline

This block models a single-port synchronous memory whose data bus can switch between reads and writes on consecutive cycles with no idle cycle in between. The trick is that write data does not come with the write command. It comes a fixed number of enabled clock edges later, the same lag that read data has behind its read command. A static mode input chooses between two latencies: two edges in pipelined mode and one edge in flow-through mode.

Commands are accepted only on enabled edges. Chip selection needs three separate enables to agree. Each write carries four active-low lane enables, one for each 9-bit lane. Because a write's data arrives after later commands may already have been accepted, the block tracks every write that is still waiting for its data. A read that hits such an address gets the merged bytes of that write, never the stale array word. The burst address counter lives outside the block. A continue cycle simply takes the address presented on the port. Output drivers are controlled by an enable signal: an output-enable input and a sleep input can switch the enable off at any time, without waiting for a clock edge.

Top module: `lw_sram`

## Requirements
- R1: The address, the controls and `d_in` are sampled on the rising edge. Lane l is bits [9l+8:9l] of the 36-bit word. A write changes lane l only when `bw_n[l]` is low, and a later read returns the stored word.
- R2: When `ce_n` is high the edge is ignored. All state and `q_out` hold. A read whose data is on the bus stays driven, and the bus stays off during a stalled write.
- R3: The block is selected only when `en1_n`=0, `en2`=1 and `en3_n`=0. On a load cycle without selection the block does nothing and the bus is not driven for that command.
- R4: A load cycle (`ld_n`=0) starts a new access. `we_n`=1 selects a read and `we_n`=0 selects a write.
- R5: `flow_mode`=0 is pipelined: read data accepted on enabled edge k is valid from enabled edge k+1 until the next enabled edge. `flow_mode`=1 is flow-through: the data is valid from edge k. `flow_mode` changes only during reset.
- R6: Write data for a write accepted on enabled edge k is sampled from `d_in` on enabled edge k+2 in pipelined mode, or on edge k+1 in flow-through mode.
- R7: A write with all `bw_n` bits high is an abort and leaves every word unchanged.
- R8: `q_drive` is high only while read data is due and `oe_n`=0 and `sleep`=0. `oe_n` and `sleep` act without a clock edge. `q_drive` is low after reset and during every write-data cycle.
- R9: A continue cycle (`ld_n`=1) repeats the kind of the previous access (read, write or deselect) at the address and lane enables presented. Selection and `we_n` are ignored on that cycle. After reset the previous kind is deselect.
- R10: A read whose address matches a write still waiting for its data returns that write's enabled lanes merged over the array word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline state |
| flow_mode | input | 1 | 1 selects flow-through, 0 selects pipelined |
| ce_n | input | 1 | Clock enable, active low |
| en1_n | input | 1 | Chip enable, active low |
| en2 | input | 1 | Chip enable, active high |
| en3_n | input | 1 | Chip enable, active low |
| ld_n | input | 1 | Low loads a new access, high continues |
| we_n | input | 1 | Low means write, high means read |
| bw_n | input | 4 | Lane write enables, active low |
| addr | input | 8 | Word address |
| d_in | input | 36 | Write data bus |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| sleep | input | 1 | Sleep, asynchronous, turns drivers off |
| q_out | output | 36 | Read data |
| q_drive | output | 1 | High while `q_out` should be driven on the shared bus |

## Verification
The assertions assume that `flow_mode` is constant outside reset and that every synchronous input settles well before the rising edge. The bench therefore changes the mode only while reset is held, and it drives all inputs on the falling edge. The asynchronous inputs `oe_n` and `sleep` are toggled in the middle of a low clock phase, and `q_drive` is checked before the next edge. Random traffic uses only sixteen addresses, so that reads often hit writes still waiting for their data, and it mixes stalls and continue cycles in with the other traffic.

// File: rtl/lw_pkg.sv
package lw_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_cmd_decode.sv
module lw_cmd_decode
  import lw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              ld_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              a_rd,
  output logic              a_wr,
  output logic [ADDR_W-1:0] a_addr,
  output logic [LANES-1:0]  a_mask
);
  op_e  a_op;
  op_e  nxt_op;
  logic sel;

  // A continue cycle inherits the kind held in the command stage.
  always_comb begin
    sel = !en1_n && en2 && !en3_n;
    if (!ld_n) nxt_op = !sel ? OP_IDLE : (we_n ? OP_READ : OP_WRITE);
    else       nxt_op = a_op;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_op   <= OP_IDLE;
      a_addr <= '0;
      a_mask <= '0;
    end else if (!ce_n) begin
      a_op   <= nxt_op;
      a_addr <= addr;
      a_mask <= ~bw_n;
    end
  end

  assign a_rd = (a_op == OP_READ);
  assign a_wr = (a_op == OP_WRITE);

  assert_desel_R3: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !ld_n && !sel) |=> (!a_rd && !a_wr));

  assert_load_kind_R4: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !ld_n && sel) |=> (a_rd == $past(we_n) && a_wr == !$past(we_n)));

  assert_idle_cont_R9: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && ld_n && !a_rd && !a_wr) |=> (!a_rd && !a_wr));
endmodule

// File: rtl/lw_byte_ram.sv
module lw_byte_ram #(
  parameter  int ADDR_W = 8,
  parameter  int LANES  = 4,
  parameter  int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Byte-write port: one lane slice per enable bit.
  always_ff @(posedge clk) begin
    if (en && wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_mask[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  // Read-first synchronous port; same-edge writes are patched downstream.
  always_ff @(posedge clk) begin
    if (rst)     rd_data <= '0;
    else if (en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/lw_read_path.sv
module lw_read_path #(
  parameter  int ADDR_W = 8,
  parameter  int LANES  = 4,
  parameter  int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              flow,
  input  logic [DATA_W-1:0] ram_q,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_rd,
  input  logic              b_rd,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q_out,
  output logic              out_valid
);
  logic [LANES-1:0]  hit1_mask, hit2_mask, m1_mask;
  logic [DATA_W-1:0] m1_data, rd1, rd2_d, q2;

  // First patch point: the write landing on the edge the read is accepted.
  // Second patch point: the write landing one edge later (pipelined only).
  always_comb begin
    hit1_mask = (wr_go && wr_addr == cmd_addr) ? wr_mask : '0;
    hit2_mask = (wr_go && wr_addr == a_addr)   ? wr_mask : '0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd1[g*LANE_W +: LANE_W]   = m1_mask[g]   ? m1_data[g*LANE_W +: LANE_W] : ram_q[g*LANE_W +: LANE_W];
    assign rd2_d[g*LANE_W +: LANE_W] = hit2_mask[g] ? wr_data[g*LANE_W +: LANE_W] : rd1[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m1_mask <= '0;
      m1_data <= '0;
      q2      <= '0;
    end else if (en) begin
      m1_mask <= hit1_mask;
      m1_data <= wr_data;
      q2      <= rd2_d;
    end
  end

  assign q_out     = flow ? rd1  : q2;
  assign out_valid = flow ? a_rd : b_rd;

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(q_out) && $stable(out_valid)));
endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter  int ADDR_W = 8,
  parameter  int LANES  = 4,
  parameter  int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flow_mode,
  input  logic              ce_n,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              ld_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d_in,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] q_out,
  output logic              q_drive
);
  logic              en;
  logic              a_rd, a_wr, b_rd, b_wr;
  logic [ADDR_W-1:0] a_addr, b_addr, wr_addr;
  logic [LANES-1:0]  a_mask, b_mask, wr_mask;
  logic              wr_go, out_valid;
  logic [DATA_W-1:0] ram_q;

  assign en = !ce_n;

  lw_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_decode (
    .clk(clk), .rst(rst), .ce_n(ce_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
    .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .a_rd(a_rd), .a_wr(a_wr), .a_addr(a_addr), .a_mask(a_mask)
  );

  // Second command stage: holds the access one enabled edge older.
  always_ff @(posedge clk) begin
    if (rst) begin
      b_rd   <= 1'b0;
      b_wr   <= 1'b0;
      b_addr <= '0;
      b_mask <= '0;
    end else if (en) begin
      b_rd   <= a_rd;
      b_wr   <= a_wr;
      b_addr <= a_addr;
      b_mask <= a_mask;
    end
  end

  // The write whose data is on d_in this cycle.
  always_comb begin
    if (flow_mode) begin
      wr_go = a_wr; wr_addr = a_addr; wr_mask = a_mask;
    end else begin
      wr_go = b_wr; wr_addr = b_addr; wr_mask = b_mask;
    end
  end

  lw_byte_ram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
    .clk(clk), .rst(rst), .en(en), .rd_addr(addr), .rd_data(ram_q),
    .wr_en(wr_go), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(d_in)
  );

  lw_read_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rpath (
    .clk(clk), .rst(rst), .en(en), .flow(flow_mode), .ram_q(ram_q),
    .cmd_addr(addr), .a_addr(a_addr), .a_rd(a_rd), .b_rd(b_rd),
    .wr_go(wr_go), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(d_in),
    .q_out(q_out), .out_valid(out_valid)
  );

  assign q_drive = out_valid && !oe_n && !sleep;

  assert_write_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> !q_drive);

  assert_flow_read_R5: assert property (@(posedge clk) disable iff (rst)
    (flow_mode && en && !ld_n && !en1_n && en2 && !en3_n && we_n) |=> out_valid);

  assert_mode_static_R5: assert property (@(posedge clk) disable iff (rst)
    $stable(flow_mode));

  assert_pipe_write_R6: assert property (@(posedge clk) disable iff (rst)
    (en && a_wr && !flow_mode) |=> wr_go);
endmodule

// File: tb/test_lw_sram.sv
module test_lw_sram;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst, flow_mode, ce_n, en1_n, en2, en3_n, ld_n, we_n, oe_n, sleep;
  logic [LANES-1:0]  bw_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] d_in, q_out;
  logic              q_drive;

  lw_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_lw_sram (
    .clk(clk), .rst(rst), .flow_mode(flow_mode), .ce_n(ce_n), .en1_n(en1_n),
    .en2(en2), .en3_n(en3_n), .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .d_in(d_in), .oe_n(oe_n), .sleep(sleep), .q_out(q_out), .q_drive(q_drive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [DATA_W-1:0] ref_mem [DEPTH];
  int                wq_addr[$], wq_cnt[$], rq_addr[$], rq_cnt[$];
  logic [LANES-1:0]  wq_mask[$];
  int                last_kind;   // 0 deselect, 1 read, 2 write
  int                lat;
  bit                exp_valid;
  logic [DATA_W-1:0] exp_data;
  int                vectors = 0, miscompares = 0;
  string             tag = "R8 reset";
  bit                done = 0;

  task automatic model_edge();
    int kind;
    if (rst) begin
      wq_addr.delete(); wq_cnt.delete(); wq_mask.delete();
      rq_addr.delete(); rq_cnt.delete();
      last_kind = 0; exp_valid = 0;
      return;
    end
    if (ce_n) return;
    foreach (wq_cnt[i]) wq_cnt[i]--;
    while (wq_cnt.size() > 0 && wq_cnt[0] == 0) begin
      for (int l = 0; l < LANES; l++)
        if (wq_mask[0][l]) ref_mem[wq_addr[0]][l*LANE_W +: LANE_W] = d_in[l*LANE_W +: LANE_W];
      void'(wq_addr.pop_front()); void'(wq_cnt.pop_front()); void'(wq_mask.pop_front());
    end
    if (!ld_n) kind = (!en1_n && en2 && !en3_n) ? (we_n ? 1 : 2) : 0;
    else       kind = last_kind;
    last_kind = kind;
    if (kind == 2) begin
      wq_addr.push_back(int'(addr)); wq_cnt.push_back(lat); wq_mask.push_back(~bw_n);
    end
    if (kind == 1) begin
      rq_addr.push_back(int'(addr)); rq_cnt.push_back(lat);
    end
    exp_valid = 0;
    foreach (rq_cnt[i]) rq_cnt[i]--;
    while (rq_cnt.size() > 0 && rq_cnt[0] == 0) begin
      exp_valid = 1;
      exp_data  = ref_mem[rq_addr[0]];
      void'(rq_addr.pop_front()); void'(rq_cnt.pop_front());
    end
  endtask

  task automatic compare();
    bit want_drive;
    want_drive = exp_valid && !oe_n && !sleep;
    vectors++;
    if (q_drive !== want_drive) begin
      miscompares++;
      $display("FAIL %s: q_drive=%0b expected %0b", tag, q_drive, want_drive);
    end else if (want_drive && q_out !== exp_data) begin
      miscompares++;
      $display("FAIL %s: q_out=%h expected %h", tag, q_out, exp_data);
    end
  endtask

  task automatic cyc(input logic c, input logic e1, input logic e2, input logic e3,
                     input logic ld, input logic we, input logic [LANES-1:0] bw,
                     input logic [ADDR_W-1:0] a);
    ce_n = c; en1_n = e1; en2 = e2; en3_n = e3; ld_n = ld; we_n = we; bw_n = bw; addr = a;
    d_in = DATA_W'({$urandom(), $urandom()});
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic rd(input int a);                  cyc(0, 0, 1, 0, 0, 1, 4'hF, ADDR_W'(a)); endtask
  task automatic wr(input int a, input logic [3:0] bw); cyc(0, 0, 1, 0, 0, 0, bw, ADDR_W'(a)); endtask
  task automatic desel();                          cyc(0, 1, 1, 0, 0, 1, 4'hF, '0); endtask
  task automatic cont(input int a, input logic [3:0] bw); cyc(0, 1, 0, 1, 1, 0, bw, ADDR_W'(a)); endtask
  task automatic stall();                          cyc(1, 0, 1, 0, 0, 0, 4'h0, ADDR_W'($urandom_range(0, 15))); endtask

  // Toggle the asynchronous controls within the low phase (R8).
  task automatic async_probe();
    oe_n = 1; #1; vectors++;
    if (q_drive !== 1'b0) begin miscompares++; $display("FAIL R8 async oe_n: q_drive=%0b expected 0", q_drive); end
    oe_n = 0; sleep = 1; #1; vectors++;
    if (q_drive !== 1'b0) begin miscompares++; $display("FAIL R8 async sleep: q_drive=%0b expected 0", q_drive); end
    sleep = 0; #1; vectors++;
    if (q_drive !== exp_valid) begin miscompares++; $display("FAIL R8 async restore: q_drive=%0b expected %0b", q_drive, exp_valid); end
  endtask

  task automatic run_mode(input bit f);
    rst = 1; flow_mode = f; lat = f ? 1 : 2;
    tag = "R8 reset";
    for (int i = 0; i < 3; i++) desel();
    rst = 0;
    desel();
    tag = "R1 fill";
    for (int a = 0; a < DEPTH; a++) wr(a, 4'h0);
    for (int i = 0; i < 3; i++) desel();
    tag = "R4 R5 R6 turnaround";
    rd(3); wr(3, 4'h0); rd(3); rd(7); wr(7, 4'b1010); wr(8, 4'h0); rd(7); rd(8);
    for (int i = 0; i < 3; i++) desel();
    tag = "R10 coherence";
    wr(9, 4'h0); rd(9); wr(9, 4'b1110); rd(9); rd(9); wr(9, 4'b0111); wr(9, 4'b1101); rd(9);
    for (int i = 0; i < 3; i++) desel();
    tag = "R7 abort";
    wr(10, 4'hF); rd(10); wr(10, 4'hF); wr(10, 4'hF); rd(10);
    for (int i = 0; i < 3; i++) desel();
    tag = "R3 deselect";
    cyc(0, 1, 1, 0, 0, 0, 4'h0, 8'd11); cyc(0, 0, 0, 0, 0, 0, 4'h0, 8'd11);
    cyc(0, 0, 1, 1, 0, 1, 4'hF, 8'd11); rd(11);
    for (int i = 0; i < 3; i++) desel();
    tag = "R9 continue";
    rd(12); cont(13, 4'hF); cont(14, 4'h0); desel(); cont(15, 4'h0); cont(16, 4'h0);
    rd(15); wr(17, 4'h0); cont(18, 4'b0011); cont(19, 4'hF); rd(18); rd(19);
    for (int i = 0; i < 3; i++) desel();
    tag = "R2 stall";
    rd(20); stall(); stall(); rd(21); stall(); wr(22, 4'h0); stall(); stall(); rd(22); stall();
    for (int i = 0; i < 3; i++) desel();
    tag = "R8 output controls";
    oe_n = 1; rd(23); rd(24); oe_n = 0; sleep = 1; rd(25); sleep = 0; desel();
    rd(26); rd(27); async_probe(); desel(); async_probe(); desel();
    tag = "R6 R10 random mix";
    for (int i = 0; i < 1500; i++) begin
      cyc(($urandom_range(0, 7) == 0), ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) != 0),
          ($urandom_range(0, 9) == 0), ($urandom_range(0, 4) == 0), $urandom_range(0, 1) != 0,
          LANES'($urandom()), ADDR_W'($urandom_range(0, 15)));
    end
    for (int i = 0; i < 3; i++) desel();
  endtask

  initial begin
    rst = 1; flow_mode = 0; ce_n = 0; en1_n = 1; en2 = 1; en3_n = 0; ld_n = 0; we_n = 1;
    bw_n = '1; addr = '0; d_in = '0; oe_n = 0; sleep = 0; lat = 2; last_kind = 0;
    exp_valid = 0; exp_data = '0;
    @(negedge clk);
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run still busy, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule